// File: doc/BRIEF.md
# Multichannel ADC Channel Sequencer

This block decides which of eight analog inputs a successive-approximation converter samples on each conversion start. Software writes a channel-enable mask and a repeat flag. The block then walks the enabled channels from low to high numbers, one channel per conversion start. With repeat off it stops after the highest enabled channel. With repeat on it wraps back to the lowest enabled channel and keeps going. Every register write restarts the walk at the lowest enabled channel.

Results come out one frame late. The converted word presented at conversion start N+1 belongs to the channel that was picked at start N. The block tags that word with a 4-bit channel identifier. When no conversion stands behind an output frame, the word is all ones and the valid flag is low. This happens in the first frame after a write, after a finished one-shot walk, and with an empty mask. The conversion start marks the point in the serial frame where the input multiplexer advances, which is the 14th falling serial clock edge. The serial shifter, the track-and-hold and the comparator are outside this block.

Top module: `chan_seq`

## Requirements
- R1: `mux_vld` high means that `mux_addr` names a channel whose bit is set in the mask last written. Mask bit i enables channel i. An accepted start converts the channel shown on `mux_addr` only while `mux_vld` is high.
- R2: Successive accepted starts convert the enabled channels in strictly ascending channel order.
- R3: With `cfg_repeat`=0, `mux_vld` falls after the start that converts the highest enabled channel. It stays low, and later frames carry no conversion, until the next write.
- R4: With `cfg_repeat`=1, the start after the highest enabled channel converts the lowest enabled channel again. A mask with a single bit set converts that channel on every start.
- R5: A write (`cfg_wr`=1) loads mask and repeat. On the next cycle `mux_addr` is the lowest enabled channel, even when the mask is unchanged. When `cfg_wr` and `conv_start` are high in the same cycle, the write wins and the start is dropped.
- R6: An accepted start (`conv_start`=1, `cfg_wr`=0) registers `conv_data` as the result of the channel converted at the previous accepted start. The result appears on the outputs in the following cycle.
- R7: An output frame with no conversion behind it shows `res_vld`=0, `res_word` all ones and `res_tag`=0. This covers the first frame after a write, a finished walk and an empty mask. A write also forces this state on the next cycle.
- R8: `res_tag` is 4 bits wide. Bit 3 is 0, and bits 2:0 hold the channel number in binary.
- R9: After reset the mask is empty, `mux_vld`=0, `res_vld`=0, `res_tag`=0 and `res_word` is all ones. Starts in this state produce invalid frames.
- R10: Outputs change only on a write or an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register-written strobe, one cycle |
| cfg_mask | input | 8 | Channel-enable mask, bit i enables channel i |
| cfg_repeat | input | 1 | 1 = cycle the selected channels endlessly |
| conv_start | input | 1 | Conversion-start strobe, one cycle per frame |
| conv_data | input | 10 | Converted word of the previous frame's conversion |
| mux_addr | output | 3 | Channel the next start converts |
| mux_vld | output | 1 | A channel is pending for the next start |
| res_vld | output | 1 | Output frame carries a real result |
| res_tag | output | 4 | Channel identifier of the result |
| res_word | output | 10 | Result word, all ones when invalid |

## Verification
The walk is tried with these masks:
- A sparse mask with gaps (channels 1, 2, 5, 7), which shows whether the scan skips disabled channels and stops after the top one.
- Masks holding only the two end channels, and only one inner channel, under repeat. These show whether the wrap lands on the lowest set bit, including a wrap onto the same channel.
- A full mask under repeat, and the top channel alone without repeat.
- A rewrite of an unchanged mask partway through a walk, a write that lands in the same cycle as a start, and the empty mask.

Each frame's expected tag, word and next multiplexer address come from a model of the walk that is kept apart from the design.

// File: rtl/chseq_pkg.sv
package chseq_pkg;

  localparam int NCH_DEF   = 8;
  localparam int RES_W_DEF = 10;
  localparam int TAG_W_DEF = 4;
  localparam int SCAN_MAX  = 32;

  // Lowest set bit of m at or above index 'from'; returns {hit, index}.
  function automatic logic [5:0] find_up(input logic [SCAN_MAX-1:0] m, input int from);
    logic [5:0] r;
    r = 6'd0;
    for (int i = SCAN_MAX - 1; i >= 0; i--) begin
      if (m[i] && (i >= from)) r = {1'b1, 5'(i)};
    end
    return r;
  endfunction

endpackage

// File: rtl/chseq_scan.sv
module chseq_scan #(
  parameter int NCH  = chseq_pkg::NCH_DEF,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]  mask,
  input  logic [CH_W:0]   from_idx,
  output logic            hit,
  output logic [CH_W-1:0] idx
);
  import chseq_pkg::*;

  logic [SCAN_MAX-1:0] m_wide;
  logic [5:0]          found;

  generate
    if (NCH < SCAN_MAX) begin : g_pad
      assign m_wide = {{(SCAN_MAX - NCH){1'b0}}, mask};
    end else begin : g_full
      assign m_wide = mask[SCAN_MAX-1:0];
    end
  endgenerate

  always_comb begin
    found = find_up(m_wide, int'(from_idx));
    hit   = found[5];
    idx   = found[CH_W-1:0];
  end

endmodule

// File: rtl/chseq_ctrl.sv
module chseq_ctrl #(
  parameter int NCH  = chseq_pkg::NCH_DEF,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [NCH-1:0]  cfg_mask,
  input  logic            cfg_repeat,
  input  logic            conv_start,
  output logic [CH_W-1:0] ptr,
  output logic            ptr_vld,
  output logic [CH_W-1:0] infl_ch,
  output logic            infl_vld
);
  localparam logic [NCH-1:0] ONE_N = NCH'(1);

  logic [NCH-1:0]  mask_q;
  logic            rep_q;
  logic [CH_W-1:0] ptr_q;
  logic            pvld_q;
  logic [CH_W-1:0] infl_ch_q;
  logic            infl_vld_q;

  logic            nx_hit, lo_hit, wr_hit;
  logic [CH_W-1:0] nx_idx, lo_idx, wr_idx;
  logic [CH_W:0]   nx_from;

  // Named events for the checks below.
  logic take, adv_evt, wrap_evt, done_evt;

  assign nx_from  = {1'b0, ptr_q} + 1'b1;
  assign take     = conv_start && !cfg_wr;
  assign adv_evt  = take && pvld_q && nx_hit;
  assign wrap_evt = take && pvld_q && !nx_hit && rep_q;
  assign done_evt = take && pvld_q && !nx_hit && !rep_q;

  chseq_scan #(.NCH(NCH), .CH_W(CH_W)) u_scan_next (
    .mask(mask_q), .from_idx(nx_from), .hit(nx_hit), .idx(nx_idx));
  chseq_scan #(.NCH(NCH), .CH_W(CH_W)) u_scan_low (
    .mask(mask_q), .from_idx('0), .hit(lo_hit), .idx(lo_idx));
  chseq_scan #(.NCH(NCH), .CH_W(CH_W)) u_scan_wr (
    .mask(cfg_mask), .from_idx('0), .hit(wr_hit), .idx(wr_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      rep_q      <= 1'b0;
      ptr_q      <= '0;
      pvld_q     <= 1'b0;
      infl_ch_q  <= '0;
      infl_vld_q <= 1'b0;
    end else if (cfg_wr) begin
      mask_q     <= cfg_mask;
      rep_q      <= cfg_repeat;
      ptr_q      <= wr_idx;
      pvld_q     <= wr_hit;
      infl_ch_q  <= '0;
      infl_vld_q <= 1'b0;
    end else if (take) begin
      infl_ch_q  <= ptr_q;
      infl_vld_q <= pvld_q;
      if (adv_evt) begin
        ptr_q <= nx_idx;
      end else if (wrap_evt) begin
        ptr_q  <= lo_idx;
        pvld_q <= lo_hit;
      end else if (done_evt) begin
        pvld_q <= 1'b0;
      end
    end
  end

  assign ptr      = ptr_q;
  assign ptr_vld  = pvld_q;
  assign infl_ch  = infl_ch_q;
  assign infl_vld = infl_vld_q;

  a_r1_sel_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    pvld_q |-> mask_q[ptr_q]);
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (ptr_q > $past(ptr_q)) && pvld_q);
  a_r3_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !pvld_q);
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!pvld_q && !cfg_wr) |=> !pvld_q);
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> pvld_q && (ptr_q <= $past(ptr_q)));
  a_r5_restart_vld: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (pvld_q == (|$past(cfg_mask))) && !infl_vld_q);
  a_r5_restart_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && |cfg_mask) |=> ($countones(mask_q & ((ONE_N << ptr_q) - ONE_N)) == 0));

endmodule

// File: rtl/chseq_respipe.sv
module chseq_respipe #(
  parameter int RES_W = chseq_pkg::RES_W_DEF,
  parameter int CH_W  = 3,
  parameter int TAG_W = chseq_pkg::TAG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             src_vld,
  input  logic [CH_W-1:0]  src_ch,
  input  logic [RES_W-1:0] src_word,
  output logic             res_vld,
  output logic [TAG_W-1:0] res_tag,
  output logic [RES_W-1:0] res_word
);
  localparam logic [RES_W-1:0] NO_DATA = '1;

  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  logic [RES_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      word_q <= NO_DATA;
    end else if (clr) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      word_q <= NO_DATA;
    end else if (take) begin
      vld_q  <= src_vld;
      tag_q  <= src_vld ? TAG_W'(src_ch) : '0;
      word_q <= src_vld ? src_word : NO_DATA;
    end
  end

  assign res_vld  = vld_q;
  assign res_tag  = tag_q;
  assign res_word = word_q;

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && src_vld) |=> res_vld && (res_tag[CH_W-1:0] == $past(src_ch))
                                   && (res_word == $past(src_word)));
  a_r7_invalid_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> (res_word == NO_DATA) && (res_tag == '0));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !res_vld);
  a_r8_tag_msb: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_tag[TAG_W-1:CH_W] == '0));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clr) |=> $stable(res_vld) && $stable(res_tag) && $stable(res_word));

endmodule

// File: rtl/chan_seq.sv
module chan_seq #(
  parameter int NCH   = chseq_pkg::NCH_DEF,
  parameter int RES_W = chseq_pkg::RES_W_DEF,
  parameter int TAG_W = chseq_pkg::TAG_W_DEF,
  parameter int CH_W  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [NCH-1:0]   cfg_mask,
  input  logic             cfg_repeat,
  input  logic             conv_start,
  input  logic [RES_W-1:0] conv_data,
  output logic [CH_W-1:0]  mux_addr,
  output logic             mux_vld,
  output logic             res_vld,
  output logic [TAG_W-1:0] res_tag,
  output logic [RES_W-1:0] res_word
);
  logic            take;
  logic [CH_W-1:0] infl_ch;
  logic            infl_vld;

  assign take = conv_start && !cfg_wr;

  chseq_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask),
    .cfg_repeat(cfg_repeat), .conv_start(conv_start),
    .ptr(mux_addr), .ptr_vld(mux_vld), .infl_ch(infl_ch), .infl_vld(infl_vld));

  chseq_respipe #(.RES_W(RES_W), .CH_W(CH_W), .TAG_W(TAG_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .take(take),
    .src_vld(infl_vld), .src_ch(infl_ch), .src_word(conv_data),
    .res_vld(res_vld), .res_tag(res_tag), .res_word(res_word));

  a_r6_pending_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mux_vld) |=> (infl_vld && (infl_ch == $past(mux_addr))));

endmodule

// File: tb/chan_seq_tb_top.sv
module chan_seq_tb_top;

  typedef struct {
    logic       vld;
    logic [3:0] tag;
    logic [9:0] word;
    logic       mvld;
    logic [2:0] maddr;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_mask = 8'h00;
  logic       cfg_repeat = 1'b0;
  logic       conv_start = 1'b0;
  logic [9:0] conv_data = 10'h000;
  logic [2:0] mux_addr;
  logic       mux_vld;
  logic       res_vld;
  logic [3:0] res_tag;
  logic [9:0] res_word;

  int n_chk = 0;
  int n_err = 0;
  exp_t exp_q[$];

  // Bench model of the walk.
  int m_mask = 0;
  bit m_rep = 0;
  int m_ptr = -1;
  int m_infl = -1;

  always #2.5 clk = ~clk;

  chan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask),
    .cfg_repeat(cfg_repeat), .conv_start(conv_start), .conv_data(conv_data),
    .mux_addr(mux_addr), .mux_vld(mux_vld), .res_vld(res_vld),
    .res_tag(res_tag), .res_word(res_word));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int first_from(int from);
    for (int j = from; j < 8; j++) if (m_mask[j]) return j;
    return -1;
  endfunction

  task automatic check_mux(string req);
    check(req, "mux_vld", 32'(mux_vld), 32'(m_ptr >= 0));
    if (m_ptr >= 0) check(req, "mux_addr", 32'(mux_addr), 32'(m_ptr));
  endtask

  task automatic write_cfg(logic [7:0] mask, bit rep);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mask = mask; cfg_repeat = rep;
    m_mask = int'(mask); m_rep = rep; m_ptr = first_from(0); m_infl = -1;
    @(negedge clk);
    cfg_wr = 1'b0;
    check_mux("R5");
    check("R7", "res_vld after write", 32'(res_vld), 32'd0);
    check("R7", "res_word after write", 32'(res_word), 32'h3FF);
  endtask

  task automatic frame(logic [9:0] data, string req);
    exp_t e;
    @(negedge clk);
    conv_start = 1'b1; conv_data = data;
    e.vld  = (m_infl >= 0);
    e.tag  = e.vld ? 4'(m_infl) : 4'h0;
    e.word = e.vld ? data : 10'h3FF;
    m_infl = m_ptr;
    if (m_ptr >= 0) begin
      int n;
      n = first_from(m_ptr + 1);
      if (n < 0 && m_rep) n = first_from(0);
      m_ptr = n;
    end
    e.mvld  = (m_ptr >= 0);
    e.maddr = (m_ptr >= 0) ? 3'(m_ptr) : 3'd0;
    e.req   = req;
    exp_q.push_back(e);
    @(negedge clk);
    conv_start = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compare every accepted start against the scoreboard.
  always begin
    @(posedge clk);
    if (conv_start === 1'b1 && cfg_wr !== 1'b1) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check("R6", "unexpected frame", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "res_vld", 32'(res_vld), 32'(e.vld));
        check(e.req, "res_tag", 32'(res_tag), 32'(e.tag));
        check("R8", "tag msb", 32'(res_tag[3]), 32'd0);
        check(e.req, "res_word", 32'(res_word), 32'(e.word));
        check("R1", "mux_vld", 32'(mux_vld), 32'(e.mvld));
        if (e.mvld) check("R1", "mux_addr", 32'(mux_addr), 32'(e.maddr));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", "mux_vld", 32'(mux_vld), 32'd0);
    check("R9", "res_vld", 32'(res_vld), 32'd0);
    check("R9", "res_tag", 32'(res_tag), 32'd0);
    check("R9", "res_word", 32'(res_word), 32'h3FF);
    frame(10'h011, "R9");
    frame(10'h012, "R9");

    // Sparse mask, one pass: R2, R3, R6
    write_cfg(8'b1010_0110, 1'b0);
    for (int k = 0; k < 6; k++) frame(10'(100 + 7 * k), "R2");
    frame(10'h155, "R3");

    // R10: hold between starts
    repeat (4) @(negedge clk);
    check("R10", "res_vld hold", 32'(res_vld), 32'd0);
    check("R10", "res_word hold", 32'(res_word), 32'h3FF);

    // R5: rewrite unchanged mask partway
    write_cfg(8'b1010_0110, 1'b0);
    frame(10'h0A0, "R5");
    frame(10'h0A1, "R6");
    write_cfg(8'b1010_0110, 1'b0);
    frame(10'h0A2, "R5");
    frame(10'h0A3, "R5");

    // R4: wrap with end channels, then single-channel repeat
    write_cfg(8'b1000_0001, 1'b1);
    for (int k = 0; k < 6; k++) frame(10'(200 + k), "R4");
    write_cfg(8'b0001_0000, 1'b1);
    for (int k = 0; k < 4; k++) frame(10'(300 + k), "R4");
    repeat (3) @(negedge clk);
    check("R10", "res_tag hold", 32'(res_tag), 32'h4);
    check("R10", "res_word hold", 32'(res_word), 32'(303));

    // Top channel alone, no repeat: R3
    write_cfg(8'b1000_0000, 1'b0);
    for (int k = 0; k < 4; k++) frame(10'(400 + k), "R3");

    // Full mask with repeat: R2, R4
    write_cfg(8'hFF, 1'b1);
    for (int k = 0; k < 11; k++) frame(10'(500 + 3 * k), "R4");

    // R5: write and start in the same cycle, write wins
    @(negedge clk);
    cfg_wr = 1'b1; conv_start = 1'b1; cfg_mask = 8'b0110_0000; cfg_repeat = 1'b0;
    conv_data = 10'h2AA;
    m_mask = 8'b0110_0000; m_rep = 0; m_ptr = first_from(0); m_infl = -1;
    @(negedge clk);
    cfg_wr = 1'b0; conv_start = 1'b0;
    check_mux("R5");
    check("R5", "res_vld same-cycle", 32'(res_vld), 32'd0);
    frame(10'h2AB, "R5");
    frame(10'h2AC, "R6");
    frame(10'h2AD, "R3");

    // Empty mask: R7
    write_cfg(8'h00, 1'b1);
    frame(10'h123, "R7");
    frame(10'h124, "R7");

    repeat (3) @(negedge clk);
    check("R6", "scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule